// File: doc/BRIEF.md
# GPIO Bank with Edge Interrupts

A bank of 32 general-purpose pins controlled over a simple word-wide register bus. The bus has an address, a write enable, write data and a combinational read-data return. Per pin, the bank keeps a driven data value, a direction, a pull-disable flag and an alternate-function flag. The data and direction registers can be written whole, or changed through atomic set and clear aliases. When a pin is an input, its data bit also chooses between pull-up and pull-down. Pad drivers, resistors and the alternate peripherals sit outside the block. The bank only presents per-pin control outputs for them.

Pin inputs pass through a two-flop synchronizer. Each pin can flag a rising edge, a falling edge, or both, through two independent mask registers. Every qualified edge is latched into a status register. Writing ones to a clear register removes status bits. A single interrupt line is high while any status bit is set. A larger pin count is built by placing several banks at a fixed address stride.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset, every register reads zero. All pins are inputs (pinOe zero), pullEn is all ones, pullUp is zero and irq is low.
- R2: A write to offset 0x00 loads the data register. A write to 0x04 sets the data bits where the word has ones, and a write to 0x08 clears them. Zero bits leave the register unchanged. pinOut shows the data register.
- R3: A write to 0x10 loads the direction register (1 = output). Writes to 0x14 and 0x18 set and clear its bits where the word has ones. pinOe bit is high when the direction bit is 1 and the alternate bit is 0.
- R4: Reading 0x00 returns the register value for output pins. For input pins it returns the pin level delayed by two clock edges through the synchronizer.
- R5: For an input pin whose pull-disable bit (register 0x0C, readable) is 0, pullEn is 1 and pullUp equals the pin's data bit. A pull-disable bit of 1, or an output pin, gives pullEn 0 and pullUp 0.
- R6: Register 0x20 is the alternate-function select, shown on altSel. A pin with its bit at 1 has pinOe and pullEn forced to 0.
- R7: With its bit set in the rising mask (0x40), a low-to-high pin change sets that pin's status bit (read at 0x48) on the third clock edge after the change. With the mask bit at 0, the status bit stays clear.
- R8: With its bit set in the falling mask (0x44), a high-to-low change sets the status bit with the same latency. With both masks set, both edge directions set it.
- R9: Writing 0x4C clears the status bits where the word has ones. Zero bits leave pending status untouched.
- R10: If an edge and a clear of the same bit land on the same clock edge, the status bit ends set.
- R11: irq is high exactly when at least one status bit is set.
- R12: Reads of the write-only aliases (0x04, 0x08, 0x14, 0x18, 0x4C) and of unmapped offsets return zero. Writes to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Byte offset within the bank |
| busWe | input | 1 | Write enable |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| pinIn | input | 32 | Asynchronous pin levels |
| pinOut | output | 32 | Driven data value per pin |
| pinOe | output | 32 | Output enable per pin |
| pullEn | output | 32 | Pull resistor enable per pin |
| pullUp | output | 32 | Pull polarity, 1 = up |
| altSel | output | 32 | Alternate-function hand-over per pin |
| irq | output | 1 | Bank interrupt |

## Verification
The hardest case to reach is an edge becoming visible on the very clock edge at which software clears the same status bit. The stimulus counts the synchronizer latency from the pin change and issues the clear write so that it coincides with the third clock edge. A directed sequence for each mask combination checks status one edge before the expected latency and at it. Random writes to the configuration registers, with pins held steady, cover the set/clear aliases and the combination of direction, pull and alternate selection.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int OFS_DATA     = 'h00;
  localparam int OFS_DATA_SET = 'h04;
  localparam int OFS_DATA_CLR = 'h08;
  localparam int OFS_PULL_DIS = 'h0C;
  localparam int OFS_DIR      = 'h10;
  localparam int OFS_DIR_SET  = 'h14;
  localparam int OFS_DIR_CLR  = 'h18;
  localparam int OFS_ALT      = 'h20;
  localparam int OFS_RISE     = 'h40;
  localparam int OFS_FALL     = 'h44;
  localparam int OFS_STAT     = 'h48;
  localparam int OFS_ACK      = 'h4C;

  typedef struct packed {
    logic wrData;
    logic setData;
    logic clrData;
    logic wrPull;
    logic wrDir;
    logic setDir;
    logic clrDir;
    logic wrAlt;
    logic wrRise;
    logic wrFall;
    logic ackStat;
  } bankStrobe_t;

  typedef enum logic [2:0] {
    RD_NONE, RD_DATA, RD_PULL, RD_DIR, RD_ALT, RD_RISE, RD_FALL, RD_STAT
  } rdSel_t;

endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output bankStrobe_t       strobe,
  output rdSel_t            rdSel
);

  always_comb begin
    strobe = '0;
    rdSel  = RD_NONE;
    case (busAddr)
      ADDR_W'(OFS_DATA):     begin strobe.wrData  = busWe; rdSel = RD_DATA; end
      ADDR_W'(OFS_DATA_SET): strobe.setData = busWe;
      ADDR_W'(OFS_DATA_CLR): strobe.clrData = busWe;
      ADDR_W'(OFS_PULL_DIS): begin strobe.wrPull  = busWe; rdSel = RD_PULL; end
      ADDR_W'(OFS_DIR):      begin strobe.wrDir   = busWe; rdSel = RD_DIR;  end
      ADDR_W'(OFS_DIR_SET):  strobe.setDir  = busWe;
      ADDR_W'(OFS_DIR_CLR):  strobe.clrDir  = busWe;
      ADDR_W'(OFS_ALT):      begin strobe.wrAlt   = busWe; rdSel = RD_ALT;  end
      ADDR_W'(OFS_RISE):     begin strobe.wrRise  = busWe; rdSel = RD_RISE; end
      ADDR_W'(OFS_FALL):     begin strobe.wrFall  = busWe; rdSel = RD_FALL; end
      ADDR_W'(OFS_STAT):     rdSel = RD_STAT;
      ADDR_W'(OFS_ACK):      strobe.ackStat = busWe;
      default:               ;
    endcase
  end

endmodule

// File: rtl/gpio_bank_dp.sv
module gpio_bank_dp
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  bankStrobe_t         strobe,
  input  rdSel_t              rdSel,
  input  logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W-1:0]   busRdata,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  output logic [NUM_PINS-1:0] pullEn,
  output logic [NUM_PINS-1:0] pullUp,
  output logic [NUM_PINS-1:0] altSel,
  output logic                irq
);

  logic [NUM_PINS-1:0] wordIn;
  logic [NUM_PINS-1:0] dataReg, dirReg, pullDisReg, altReg, riseMask, fallMask;
  logic [NUM_PINS-1:0] syncA, syncB, syncPrev;
  logic [NUM_PINS-1:0] statReg;
  logic [NUM_PINS-1:0] levelView;

  assign wordIn = busWdata[NUM_PINS-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReg    <= '0;
      dirReg     <= '0;
      pullDisReg <= '0;
      altReg     <= '0;
      riseMask   <= '0;
      fallMask   <= '0;
    end else begin
      if (strobe.wrData)       dataReg <= wordIn;
      else if (strobe.setData) dataReg <= dataReg | wordIn;
      else if (strobe.clrData) dataReg <= dataReg & ~wordIn;
      if (strobe.wrDir)        dirReg  <= wordIn;
      else if (strobe.setDir)  dirReg  <= dirReg | wordIn;
      else if (strobe.clrDir)  dirReg  <= dirReg & ~wordIn;
      if (strobe.wrPull) pullDisReg <= wordIn;
      if (strobe.wrAlt)  altReg     <= wordIn;
      if (strobe.wrRise) riseMask   <= wordIn;
      if (strobe.wrFall) fallMask   <= wordIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA    <= '0;
      syncB    <= '0;
      syncPrev <= '0;
    end else begin
      syncA    <= pinIn;
      syncB    <= syncA;
      syncPrev <= syncB;
    end
  end

  // One status cell per pin: an edge event outranks a clear in the same cycle.
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic edgeHit;
    assign edgeHit = (riseMask[p] & syncB[p] & ~syncPrev[p]) |
                     (fallMask[p] & ~syncB[p] & syncPrev[p]);
    always_ff @(posedge clk) begin
      if (!rstN)                          statReg[p] <= 1'b0;
      else if (edgeHit)                   statReg[p] <= 1'b1;
      else if (strobe.ackStat && wordIn[p]) statReg[p] <= 1'b0;
    end
    assign levelView[p] = dirReg[p] ? dataReg[p] : syncB[p];
    assign pinOe[p]     = dirReg[p] & ~altReg[p];
    assign pullEn[p]    = ~dirReg[p] & ~pullDisReg[p] & ~altReg[p];
    assign pullUp[p]    = pullEn[p] & dataReg[p];
  end

  assign pinOut = dataReg;
  assign altSel = altReg;
  assign irq    = |statReg;

  always_comb begin
    case (rdSel)
      RD_DATA: busRdata = DATA_W'(levelView);
      RD_PULL: busRdata = DATA_W'(pullDisReg);
      RD_DIR:  busRdata = DATA_W'(dirReg);
      RD_ALT:  busRdata = DATA_W'(altReg);
      RD_RISE: busRdata = DATA_W'(riseMask);
      RD_FALL: busRdata = DATA_W'(fallMask);
      RD_STAT: busRdata = DATA_W'(statReg);
      default: busRdata = '0;
    endcase
  end

endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWe,
  input  logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W-1:0]   busRdata,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  output logic [NUM_PINS-1:0] pullEn,
  output logic [NUM_PINS-1:0] pullUp,
  output logic [NUM_PINS-1:0] altSel,
  output logic                irq
);

  bankStrobe_t strobe;
  rdSel_t      rdSel;

  gpio_bank_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr (busAddr),
    .busWe   (busWe),
    .strobe  (strobe),
    .rdSel   (rdSel)
  );

  gpio_bank_dp #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .rdSel    (rdSel),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .pinIn    (pinIn),
    .pinOut   (pinOut),
    .pinOe    (pinOe),
    .pullEn   (pullEn),
    .pullUp   (pullUp),
    .altSel   (altSel),
    .irq      (irq)
  );

endmodule

// File: rtl/gpio_edge_bank_chk.sv
module gpio_edge_bank_chk #(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic [ADDR_W-1:0]   busAddr,
  input logic                busWe,
  input logic [DATA_W-1:0]   busWdata,
  input logic [NUM_PINS-1:0] pinOut,
  input logic [NUM_PINS-1:0] pinOe,
  input logic [NUM_PINS-1:0] pullEn,
  input logic [NUM_PINS-1:0] pullUp,
  input logic [NUM_PINS-1:0] altSel,
  input logic                irq
);

  logic [NUM_PINS-1:0] wWord;
  assign wWord = busWdata[NUM_PINS-1:0];

  a_r1_reset_state: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (pinOe == '0 && pullUp == '0 && altSel == '0 && !irq));

  a_r2_data_set: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_W'('h04)) |=> ((pinOut & $past(wWord)) == $past(wWord)));

  a_r2_data_clear: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_W'('h08)) |=> ((pinOut & $past(wWord)) == '0));

  a_r3_dir_set: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_W'('h14)) |=> (((pinOe | altSel) & $past(wWord)) == $past(wWord)));

  a_r5_pull_not_on_output: assert property (@(posedge clk) disable iff (!rstN)
    (pullEn & pinOe) == '0);

  a_r5_pullup_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    (pullUp & ~pullEn) == '0);

  a_r6_alt_blocks_drive: assert property (@(posedge clk) disable iff (!rstN)
    ((pinOe | pullEn) & altSel) == '0);

endmodule

bind gpio_edge_bank gpio_edge_bank_chk #(
  .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
  .pinOut(pinOut), .pinOe(pinOe), .pullEn(pullEn), .pullUp(pullUp),
  .altSel(altSel), .irq(irq)
);

// File: tb/gpio_edge_bank_tb.sv
module gpio_edge_bank_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] pinIn = '0;
  logic [31:0] pinOut, pinOe, pullEn, pullUp, altSel;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  logic [31:0] mData = '0, mDir = '0, mPdis = '0, mAlt = '0, mRise = '0, mFall = '0;

  always #10 clk = ~clk;

  gpio_edge_bank u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
    .busRdata(busRdata), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe),
    .pullEn(pullEn), .pullUp(pullUp), .altSel(altSel), .irq(irq)
  );

  function automatic logic [31:0] expOe();   return mDir & ~mAlt; endfunction
  function automatic logic [31:0] expPen();  return ~mDir & ~mPdis & ~mAlt; endfunction
  function automatic logic [31:0] expPup();  return expPen() & mData; endfunction
  function automatic logic [31:0] expView(); return (mDir & mData) | (~mDir & pinIn); endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic modelWrite(logic [7:0] a, logic [31:0] d);
    case (a)
      8'h00: mData = d;
      8'h04: mData = mData | d;
      8'h08: mData = mData & ~d;
      8'h0C: mPdis = d;
      8'h10: mDir = d;
      8'h14: mDir = mDir | d;
      8'h18: mDir = mDir & ~d;
      8'h20: mAlt = d;
      8'h40: mRise = d;
      8'h44: mFall = d;
      default: ;
    endcase
  endtask

  task automatic checkPads(string req);
    check({req, " pinOut"}, pinOut, mData);
    check({req, " pinOe"},  pinOe,  expOe());
    check({req, " pullEn"}, pullEn, expPen());
    check({req, " pullUp"}, pullUp, expPup());
    check({req, " altSel"}, altSel, mAlt);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish();
  end

  initial begin
    logic [31:0] rd;
    logic [7:0] cfgAddr [10] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h20, 8'h40, 8'h44};
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state
    checkPads("R1");
    check("R1 irq", {31'b0, irq}, 32'b0);
    check("R1 pullEn all", pullEn, 32'hFFFF_FFFF);
    busRead(8'h00, rd); check("R1 data", rd, 32'h0);
    busRead(8'h10, rd); check("R1 dir", rd, 32'h0);
    busRead(8'h48, rd); check("R1 status", rd, 32'h0);

    // R2 R3 R5 R6 random configuration writes, pins steady
    pinIn = 32'hA5C3_0F96;
    repeat (3) @(posedge clk);
    for (int i = 0; i < 300; i++) begin
      logic [7:0] a;
      logic [31:0] d;
      a = cfgAddr[$urandom_range(9, 0)];
      d = $urandom();
      busWrite(a, d);
      modelWrite(a, d);
      checkPads("R2/R3/R5/R6 random");
      if (i % 10 == 0) begin
        busRead(8'h00, rd); check("R4 readback", rd, expView());
        busRead(8'h0C, rd); check("R5 pull-disable reg", rd, mPdis);
        busRead(8'h10, rd); check("R3 dir reg", rd, mDir);
        busRead(8'h20, rd); check("R6 alt reg", rd, mAlt);
        busRead(8'h40, rd); check("R7 rise mask reg", rd, mRise);
        busRead(8'h44, rd); check("R8 fall mask reg", rd, mFall);
      end
    end

    // Directed: clean state for edge tests
    pinIn = '0;
    foreach (cfgAddr[k]) begin
      if (cfgAddr[k] != 8'h04 && cfgAddr[k] != 8'h08 && cfgAddr[k] != 8'h14 && cfgAddr[k] != 8'h18) begin
        busWrite(cfgAddr[k], 32'h0);
        modelWrite(cfgAddr[k], 32'h0);
      end
    end
    repeat (4) @(posedge clk);
    busWrite(8'h4C, 32'hFFFF_FFFF);
    busRead(8'h48, rd); check("R9 clear all", rd, 32'h0);

    // R2 zero bits leave data alone
    busWrite(8'h00, 32'h0000_00F0); modelWrite(8'h00, 32'h0000_00F0);
    busWrite(8'h04, 32'h0000_0003); modelWrite(8'h04, 32'h0000_0003);
    check("R2 set alias", pinOut, 32'h0000_00F3);
    busWrite(8'h08, 32'h0000_0030); modelWrite(8'h08, 32'h0000_0030);
    check("R2 clear alias", pinOut, 32'h0000_00C3);
    check("R5 pullUp follows data", pullUp, 32'h0000_00C3);

    // R4 synchronizer latency on input read
    @(negedge clk) pinIn[10] = 1'b1;
    @(posedge clk);
    @(negedge clk) busAddr = 8'h00; #1 check("R4 one edge", busRdata & 32'h400, 32'h0);
    @(posedge clk);
    @(negedge clk) #1 check("R4 two edges", busRdata & 32'h400, 32'h400);
    pinIn[10] = 1'b0;
    repeat (3) @(posedge clk);

    // R7 R8 masks
    busWrite(8'h40, 32'h0000_0088); modelWrite(8'h40, 32'h0000_0088);
    busWrite(8'h44, 32'h0000_00A0); modelWrite(8'h44, 32'h0000_00A0);
    @(negedge clk) pinIn[3] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk) busAddr = 8'h48; #1 check("R7 not yet", busRdata, 32'h0);
    @(posedge clk);
    @(negedge clk) #1 check("R7 rising set", busRdata, 32'h8);
    check("R11 irq high", {31'b0, irq}, 32'h1);
    @(negedge clk) pinIn[5] = 1'b1;
    repeat (4) @(posedge clk);
    busRead(8'h48, rd); check("R8 rise ignored by fall mask", rd, 32'h8);
    @(negedge clk) pinIn[5] = 1'b0;
    repeat (3) @(posedge clk);
    busRead(8'h48, rd); check("R8 falling set", rd, 32'h28);
    @(negedge clk) pinIn[7] = 1'b1;
    repeat (3) @(posedge clk);
    busRead(8'h48, rd); check("R8 both rise", rd, 32'hA8);
    busWrite(8'h4C, 32'h0000_0080);
    @(negedge clk) pinIn[7] = 1'b0;
    repeat (3) @(posedge clk);
    busRead(8'h48, rd); check("R8 both fall", rd, 32'hA8);

    // R9 selective clear and zero write
    busWrite(8'h4C, 32'h0);
    busRead(8'h48, rd); check("R9 zero write", rd, 32'hA8);
    busWrite(8'h4C, 32'h0000_0008);
    busRead(8'h48, rd); check("R9 partial clear", rd, 32'hA0);
    busWrite(8'h4C, 32'h0000_00A0);
    busRead(8'h48, rd); check("R9 cleared", rd, 32'h0);
    check("R11 irq low", {31'b0, irq}, 32'h0);

    // R10 edge and clear on the same clock edge
    @(negedge clk) pinIn[7] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk) begin busAddr = 8'h4C; busWdata = 32'h80; busWe = 1'b1; end
    @(posedge clk);
    @(negedge clk) busWe = 1'b0;
    busRead(8'h48, rd); check("R10 edge wins", rd, 32'h80);
    check("R11 irq from edge", {31'b0, irq}, 32'h1);

    // R12 write-only aliases and unmapped offsets
    busRead(8'h04, rd); check("R12 alias reads 0", rd, 32'h0);
    busRead(8'h4C, rd); check("R12 ack reads 0", rd, 32'h0);
    busRead(8'h30, rd); check("R12 unmapped reads 0", rd, 32'h0);
    busWrite(8'h30, 32'hFFFF_FFFF);
    busWrite(8'h24, 32'hFFFF_FFFF);
    checkPads("R12 unmapped write");
    busRead(8'h40, rd); check("R12 rise mask kept", rd, mRise);
    busRead(8'h48, rd); check("R12 status kept", rd, 32'h80);

    finish();
  end

endmodule